// File: doc/BRIEF.md
# Mode-Dependent Effective Address Unit

This unit turns an addressing form and a 32-bit base register into the memory address of an operand for a small CPU with two static address modes. The narrow mode uses a 16-bit, 64-kbyte space. The wide mode uses a 24-bit, 16-Mbyte space. The unit covers four forms: plain register indirect, auto-incrementing and auto-decrementing register indirect, and an indirect branch through an 8-bit pointer in low memory. It also forms the fetch address of exception vectors.

The two auto-modifying forms return a register write-back value. That value is always computed over the full 32-bit register, so in the narrow mode a carry or borrow across bit 15 alters the upper half even though the address output drops it. The indirect branch form runs a read handshake. It raises a read request at the pointer address, holds it until the returned data is flagged valid, and then presents the branch target with a one-cycle done pulse.

Each request is a one-cycle `start` pulse. The address and write-back results appear on the registered outputs in the following cycle.

Top module: `ea_unit`

## Requirements
- R1: During and after reset, `addr_vld`, `wb_en`, `rd_req` and `done` are low, and `addr` is zero.
- R2: In the narrow mode (`wide_mode`=0), `addr` carries only the low 16 bits of the computed address, with bits 23:16 zero. In the wide mode (`wide_mode`=1), `addr` carries the low 24 bits.
- R3: Form code 0 (register indirect) gives `addr` = base in the cycle after `start`, with `addr_vld` high and `wb_en` low.
- R4: Form code 1 (post-increment) gives `addr` = base and `wb_data` = base + step, with `wb_en` high. The step is 1 for size code 0, 2 for size code 1, and 4 for size codes 2 and 3.
- R5: Form code 2 (pre-decrement) gives `addr` = base − step and `wb_data` = base − step, with `wb_en` high and the same step encoding as R4.
- R6: The write-back arithmetic spans all 32 bits in both modes. A carry or borrow across bit 15 changes bits 31:16, and without one bits 31:16 are returned unchanged.
- R7: Form code 3 (memory indirect) raises `rd_req` in the cycle after `start`, with `addr` equal to the zero-extended 8-bit `abs_ptr`. `rd_req` and `addr` hold until `rd_valid` is seen. In the next cycle `done` pulses and `rd_req` drops. `target` is `rd_data[15:0]` zero-extended in the narrow mode, and `rd_data[23:0]` in the wide mode.
- R8: Form code 4 (vector) gives `addr` = 2·`vec_num` in the narrow mode and 4·`vec_num` in the wide mode.
- R9: A `start` that arrives while a memory-indirect read is pending is ignored. `addr_vld` stays low and `addr` keeps the pointer address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | Static mode: 0 narrow (16-bit), 1 wide (24-bit) |
| start | input | 1 | One-cycle request pulse |
| form | input | 3 | Addressing form code |
| op_size | input | 2 | Operand size code |
| base_reg | input | 32 | Base register value |
| abs_ptr | input | 8 | Short absolute pointer field |
| vec_num | input | 8 | Exception vector number |
| rd_data | input | 32 | Data returned for the indirect read |
| rd_valid | input | 1 | Strobe marking `rd_data` valid |
| addr | output | 24 | Memory address |
| addr_vld | output | 1 | Pulse: a new address was formed |
| wb_data | output | 32 | Register write-back value |
| wb_en | output | 1 | Pulse: write `wb_data` back to the register |
| rd_req | output | 1 | Indirect read request, held until `rd_valid` |
| target | output | 24 | Branch target from the indirect read |
| done | output | 1 | Pulse: `target` is valid |

## Verification
The bench drives a word post-increment at 0xFFFF and a longword pre-decrement at 0x0000 in the narrow mode. A design that masked the arithmetic to 16 bits would leave the upper half unchanged instead of carrying into it or borrowing from it. A byte post-increment with no carry checks that arbitrary upper bits survive untouched. The indirect read is stretched over several wait cycles with a stray `start` in between. A design that accepted that `start` would move the address off the pointer. Read data with non-zero upper bytes exposes a narrow-mode target that leaks bits 23:16, and the two vector checks catch a 2·n or 4·n scale applied in the wrong mode.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int EA_REG_W    = 32;
    localparam int EA_ADDR_W   = 24;
    localparam int EA_NARROW_W = 16;

    typedef enum logic [2:0] {
        FORM_IND     = 3'd0,
        FORM_POSTINC = 3'd1,
        FORM_PREDEC  = 3'd2,
        FORM_MEMIND  = 3'd3,
        FORM_VECTOR  = 3'd4
    } ea_form_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ea_state_e;

    typedef struct packed {
        ea_state_e               state;
        logic [EA_ADDR_W-1:0]    addr;
        logic                    addr_vld;
        logic [EA_REG_W-1:0]     wb_data;
        logic                    wb_en;
        logic                    rd_req;
        logic [EA_ADDR_W-1:0]    target;
        logic                    done;
    } ea_regs_t;
endpackage

// File: rtl/ea_step_gen.sv
module ea_step_gen #(
    parameter int REG_W = 32
) (
    input  logic [1:0]       op_size,
    output logic [REG_W-1:0] step
);
    always_comb begin
        step = '0;
        unique case (op_size)
            2'd0:    step[0] = 1'b1;
            2'd1:    step[1] = 1'b1;
            default: step[2] = 1'b1;
        endcase
    end
endmodule

// File: rtl/ea_addr_fmt.sv
module ea_addr_fmt #(
    parameter int ADDR_W   = 24,
    parameter int NARROW_W = 16
) (
    input  logic              wide_mode,
    input  logic [ADDR_W-1:0] ea_in,
    output logic [ADDR_W-1:0] ea_out
);
    localparam int HI_W = ADDR_W - NARROW_W;

    generate
        if (HI_W > 0) begin : g_split
            assign ea_out = wide_mode ? ea_in
                                      : {{HI_W{1'b0}}, ea_in[NARROW_W-1:0]};
        end else begin : g_flat
            logic unused_mode;
            assign unused_mode = wide_mode;
            assign ea_out      = ea_in;
        end
    endgenerate
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wide_mode,
    input  logic                   start,
    input  logic [2:0]             form,
    input  logic [1:0]             op_size,
    input  logic [EA_REG_W-1:0]    base_reg,
    input  logic [7:0]             abs_ptr,
    input  logic [7:0]             vec_num,
    input  logic [EA_REG_W-1:0]    rd_data,
    input  logic                   rd_valid,
    output logic [EA_ADDR_W-1:0]   addr,
    output logic                   addr_vld,
    output logic [EA_REG_W-1:0]    wb_data,
    output logic                   wb_en,
    output logic                   rd_req,
    output logic [EA_ADDR_W-1:0]   target,
    output logic                   done
);
    localparam int PTR_PAD = EA_ADDR_W - 8;
    localparam int VN_PAD2 = EA_ADDR_W - 9;
    localparam int VN_PAD4 = EA_ADDR_W - 10;

    ea_regs_t q, d;

    logic [EA_REG_W-1:0]  step;
    logic [EA_REG_W-1:0]  inc_val;
    logic [EA_REG_W-1:0]  dec_val;
    logic [EA_ADDR_W-1:0] ea_sel;
    logic [EA_ADDR_W-1:0] ea_fmt;
    logic [EA_ADDR_W-1:0] tgt_fmt;
    logic                 unused_rd_hi;
    ea_form_e             form_e;

    assign form_e       = ea_form_e'(form);
    assign unused_rd_hi = ^rd_data[EA_REG_W-1:EA_ADDR_W];

    ea_step_gen #(.REG_W(EA_REG_W)) u_step (
        .op_size (op_size),
        .step    (step)
    );

    // Full-width update: carries and borrows reach the upper half in any mode.
    assign inc_val = base_reg + step;
    assign dec_val = base_reg - step;

    always_comb begin
        unique case (form_e)
            FORM_PREDEC: ea_sel = dec_val[EA_ADDR_W-1:0];
            FORM_MEMIND: ea_sel = {{PTR_PAD{1'b0}}, abs_ptr};
            FORM_VECTOR: ea_sel = wide_mode ? {{VN_PAD4{1'b0}}, vec_num, 2'b00}
                                            : {{VN_PAD2{1'b0}}, vec_num, 1'b0};
            default:     ea_sel = base_reg[EA_ADDR_W-1:0];
        endcase
    end

    ea_addr_fmt #(.ADDR_W(EA_ADDR_W), .NARROW_W(EA_NARROW_W)) u_fmt_ea (
        .wide_mode (wide_mode),
        .ea_in     (ea_sel),
        .ea_out    (ea_fmt)
    );

    ea_addr_fmt #(.ADDR_W(EA_ADDR_W), .NARROW_W(EA_NARROW_W)) u_fmt_tgt (
        .wide_mode (wide_mode),
        .ea_in     (rd_data[EA_ADDR_W-1:0]),
        .ea_out    (tgt_fmt)
    );

    always_comb begin
        d          = q;
        d.addr_vld = 1'b0;
        d.wb_en    = 1'b0;
        d.done     = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.addr     = ea_fmt;
                    d.addr_vld = 1'b1;
                    unique case (form_e)
                        FORM_POSTINC: begin
                            d.wb_data = inc_val;
                            d.wb_en   = 1'b1;
                        end
                        FORM_PREDEC: begin
                            d.wb_data = dec_val;
                            d.wb_en   = 1'b1;
                        end
                        FORM_MEMIND: begin
                            d.rd_req = 1'b1;
                            d.state  = ST_WAIT;
                        end
                        default: ;
                    endcase
                end
            end
            ST_WAIT: begin
                if (rd_valid) begin
                    d.rd_req = 1'b0;
                    d.done   = 1'b1;
                    d.target = tgt_fmt;
                    d.state  = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign addr     = q.addr;
    assign addr_vld = q.addr_vld;
    assign wb_data  = q.wb_data;
    assign wb_en    = q.wb_en;
    assign rd_req   = q.rd_req;
    assign target   = q.target;
    assign done     = q.done;
endmodule

// File: rtl/ea_unit_checker.sv
module ea_unit_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wide_mode,
    input logic        start,
    input logic        rd_valid,
    input logic [23:0] addr,
    input logic        addr_vld,
    input logic        wb_en,
    input logic        rd_req,
    input logic [23:0] target,
    input logic        done
);
    AST_NARROW_ADDR_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && !wide_mode) |-> (addr[23:16] == 8'h00)); // R2
    AST_NARROW_TARGET_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wide_mode) |-> (target[23:16] == 8'h00)); // R7
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(addr))); // R7
    AST_DONE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid) |=> (done && !rd_req)); // R7
    AST_WB_NOT_INDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> !rd_req); // R4
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid && start) |=> !addr_vld); // R9
endmodule

bind ea_unit ea_unit_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide_mode (wide_mode),
    .start     (start),
    .rd_valid  (rd_valid),
    .addr      (addr),
    .addr_vld  (addr_vld),
    .wb_en     (wb_en),
    .rd_req    (rd_req),
    .target    (target),
    .done      (done)
);

// File: tb/ea_unit_test.sv
module ea_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  form = 3'd0;
    logic [1:0]  op_size = 2'd0;
    logic [31:0] base_reg = '0;
    logic [7:0]  abs_ptr = '0;
    logic [7:0]  vec_num = '0;
    logic [31:0] rd_data = '0;
    logic        rd_valid = 1'b0;
    logic [23:0] addr;
    logic        addr_vld;
    logic [31:0] wb_data;
    logic        wb_en;
    logic        rd_req;
    logic [23:0] target;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ea_unit uut (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .start(start),
        .form(form), .op_size(op_size), .base_reg(base_reg), .abs_ptr(abs_ptr),
        .vec_num(vec_num), .rd_data(rd_data), .rd_valid(rd_valid),
        .addr(addr), .addr_vld(addr_vld), .wb_data(wb_data), .wb_en(wb_en),
        .rd_req(rd_req), .target(target), .done(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Pulse start for one cycle, return at the negedge where outputs are valid.
    task automatic issue(input logic wm, input logic [2:0] f, input logic [1:0] sz,
                         input logic [31:0] b, input logic [7:0] ap, input logic [7:0] vn);
        @(negedge clk);
        wide_mode = wm; form = f; op_size = sz; base_reg = b; abs_ptr = ap; vec_num = vn;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 addr_vld", {31'd0, addr_vld}, 32'd0);
        check("R1 wb_en",    {31'd0, wb_en},    32'd0);
        check("R1 rd_req",   {31'd0, rd_req},   32'd0);
        check("R1 done",     {31'd0, done},     32'd0);
        check("R1 addr",     {8'd0, addr},      32'd0);
    endtask

    task automatic t_indirect;
        issue(1'b0, 3'd0, 2'd1, 32'h1234_5678, 8'h00, 8'h00);
        check("R3 narrow addr", {8'd0, addr}, 32'h0000_5678);
        check("R2 narrow upper zero", {8'd0, addr}, 32'h0000_5678);
        check("R3 addr_vld", {31'd0, addr_vld}, 32'd1);
        check("R3 no wb", {31'd0, wb_en}, 32'd0);
        issue(1'b1, 3'd0, 2'd1, 32'h1234_5678, 8'h00, 8'h00);
        check("R2 wide addr", {8'd0, addr}, 32'h0034_5678);
    endtask

    task automatic t_postinc;
        issue(1'b0, 3'd1, 2'd1, 32'h1234_FFFF, 8'h00, 8'h00);
        check("R4 postinc addr", {8'd0, addr}, 32'h0000_FFFF);
        check("R6 carry into upper", wb_data, 32'h1235_0001);
        check("R4 wb_en", {31'd0, wb_en}, 32'd1);
        issue(1'b0, 3'd1, 2'd0, 32'h7777_0010, 8'h00, 8'h00);
        check("R6 upper unchanged", wb_data, 32'h7777_0011);
        issue(1'b1, 3'd1, 2'd3, 32'h0000_0100, 8'h00, 8'h00);
        check("R4 size3 step4", wb_data, 32'h0000_0104);
    endtask

    task automatic t_predec;
        issue(1'b0, 3'd2, 2'd2, 32'hABCD_0000, 8'h00, 8'h00);
        check("R5 predec addr", {8'd0, addr}, 32'h0000_FFFC);
        check("R6 borrow from upper", wb_data, 32'hABCC_FFFC);
        issue(1'b1, 3'd2, 2'd1, 32'h0012_3456, 8'h00, 8'h00);
        check("R5 wide predec addr", {8'd0, addr}, 32'h0012_3454);
        check("R5 wide predec wb", wb_data, 32'h0012_3454);
    endtask

    task automatic t_vector;
        issue(1'b0, 3'd4, 2'd0, 32'hFFFF_FFFF, 8'h00, 8'h05);
        check("R8 narrow vector", {8'd0, addr}, 32'h0000_000A);
        check("R8 vector no wb", {31'd0, wb_en}, 32'd0);
        issue(1'b1, 3'd4, 2'd0, 32'hFFFF_FFFF, 8'h00, 8'h05);
        check("R8 wide vector", {8'd0, addr}, 32'h0000_0014);
    endtask

    task automatic t_memind(input logic wm, input logic [23:0] exp_tgt);
        issue(wm, 3'd3, 2'd1, 32'hFFFF_FFFF, 8'h9C, 8'h00);
        check("R7 req raised", {31'd0, rd_req}, 32'd1);
        check("R7 ptr addr", {8'd0, addr}, 32'h0000_009C);
        // stray start while pending
        issue(wm, 3'd0, 2'd1, 32'h0000_4444, 8'h00, 8'h00);
        check("R9 start ignored vld", {31'd0, addr_vld}, 32'd0);
        check("R9 start ignored addr", {8'd0, addr}, 32'h0000_009C);
        check("R7 req held", {31'd0, rd_req}, 32'd1);
        rd_data = 32'hDEAD_1234; rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
        check("R7 done", {31'd0, done}, 32'd1);
        check("R7 req dropped", {31'd0, rd_req}, 32'd0);
        check("R7 target", {8'd0, target}, {8'd0, exp_tgt});
        @(negedge clk);
        check("R7 done one cycle", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_indirect();
        t_postinc();
        t_predec();
        t_vector();
        t_memind(1'b0, 24'h00_1234);
        t_memind(1'b1, 24'hAD_1234);
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule